// File: doc/BRIEF.md
# Bus Cycle Sequencer for an 8-bit Processor

This block runs the external memory bus of a small 8-bit processor, one bus cycle on every clock. Each clock the core hands it a cycle command. The command selects a program byte fetch, a data read or write through the effective address register, a stack push or pull, or one of three idle kinds. From the command the block forms the 16-bit bus address, the read/write line and the data-direction enable. It keeps the read data from useful reads, and it steps the stack pointer and program counter.

The stack pointer always names the first free byte. A push stores at the current pointer and then moves it down. A pull moves the pointer up first and reads at the new value. Idle cycles still put a defined read on the bus: at the all-ones address, at the stack pointer, or at the program counter. Their data is discarded. A synchronous load input presets both pointers. Address and read/write are combinational from the command and the current pointer values, so they are valid within the same clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted, and after its release, the stack pointer equals SP_RST (default 0x01FF), the program counter equals PC_RST (default 0xE000) and the captured read data is 0.
- R2: Command code 0 (program fetch) drives the program counter as address with read/write = 1. It captures the bus read data and advances the program counter by one at the clock edge. The stack pointer does not change.
- R3: Command codes 1 (data read) and 2 (data write) drive the effective address register as address. Code 1 reads and captures the data. Code 2 writes: read/write = 0, the data-direction enable = 1, and the write data is driven. Neither changes the stack pointer or program counter.
- R4: Command code 3 (push) writes the write data at the current stack pointer with read/write = 0, then decrements the stack pointer by one.
- R5: Command code 4 (pull) reads at stack pointer + 1 and captures the data. The stack pointer then holds that address.
- R6: Command code 5 (null cycle) reads at address 0xFFFF. The captured data, stack pointer and program counter are left unchanged.
- R7: Command code 6 (dummy stack read) reads at the current stack pointer. The captured data and both pointers are left unchanged.
- R8: Command code 7 (dummy program read) reads at the current program counter. The captured data and both pointers are left unchanged.
- R9: Read/write is a defined 0 or 1 in every cycle and is 0 exactly when the data-direction enable is 1, which happens only for codes 2 and 3.
- R10: When the load input is 1, the next stack pointer and program counter take the load values, whatever the command. The bus cycle of that same clock still uses the old pointer values and still captures data as its command requires.
- R11: Pointer arithmetic wraps modulo 2^16: a fetch at 0xFFFF leaves the program counter at 0x0000, a pull from 0xFFFF reads 0x0000, and a push at 0x0000 leaves the stack pointer at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_kind | input | 3 | Cycle command code (see requirements) |
| ear | input | 16 | Effective address for data reads and writes |
| wr_data | input | 8 | Byte to write for data writes and pushes |
| bus_rdata | input | 8 | Byte returned by memory on read cycles |
| ptr_load | input | 1 | Load both pointers from the load values at this edge |
| sp_load_val | input | 16 | Value loaded into the stack pointer |
| pc_load_val | input | 16 | Value loaded into the program counter |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_drive | output | 1 | 1 = block drives the data bus |
| bus_wdata | output | 8 | Data driven on write cycles, zero otherwise |
| rd_data | output | 8 | Last byte captured from a useful read |
| sp | output | 16 | Stack pointer (first free entry) |
| pc | output | 16 | Program counter |

## Verification
A pointer load and a pointer-stepping command can meet in one clock. Examples are a push or a fetch issued with the load input high. The bench provokes this and checks that the address of that cycle still comes from the old pointer, while the next pointer values are the loaded ones. A pull made in the same clock as a load must also still capture its byte. That confirms capture and pointer update are independent and that the load takes priority over the step.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    CYC_PROG   = 3'd0,
    CYC_DREAD  = 3'd1,
    CYC_DWRITE = 3'd2,
    CYC_PUSH   = 3'd3,
    CYC_PULL   = 3'd4,
    CYC_NULL   = 3'd5,
    CYC_DSP    = 3'd6,
    CYC_DPC    = 3'd7
  } cyc_kind_e;

  function automatic logic kind_writes(cyc_kind_e k);
    return (k == CYC_DWRITE) || (k == CYC_PUSH);
  endfunction

  function automatic logic kind_captures(cyc_kind_e k);
    return (k == CYC_PROG) || (k == CYC_DREAD) || (k == CYC_PULL);
  endfunction
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcs_ptr_reg.sv
module bcs_ptr_reg #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] RST_VAL = '0,
  parameter bit              CAN_DEC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_en,
  input  logic              dec_en,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;
  logic              dec_ok;

  generate
    if (CAN_DEC) begin : g_dec
      assign dec_ok = dec_en;
    end else begin : g_nodec
      assign dec_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    ptr_en = load | inc_en | dec_ok;
    ptr_d  = ptr_q;
    if (load)        ptr_d = load_val;
    else if (inc_en) ptr_d = ptr_q + ONE;
    else if (dec_ok) ptr_d = ptr_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= RST_VAL;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  cyc_kind_e         kind,
  input  logic [ADDR_W-1:0] ear,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic              drive,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] IDLE_ADR = '1;

  always_comb begin
    unique case (kind)
      CYC_PROG:   addr = pc;
      CYC_DREAD:  addr = ear;
      CYC_DWRITE: addr = ear;
      CYC_PUSH:   addr = sp;
      CYC_PULL:   addr = sp + ONE;
      CYC_NULL:   addr = IDLE_ADR;
      CYC_DSP:    addr = sp;
      CYC_DPC:    addr = pc;
      default:    addr = IDLE_ADR;
    endcase
    drive = kind_writes(kind);
    rw    = ~drive;
    wdata = drive ? wr_data : '0;
  end
endmodule

// File: rtl/bcs_rd_capture.sv
module bcs_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= bus_rdata;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] SP_RST = 16'h01FF,
  parameter logic [ADDR_W-1:0] PC_RST = 16'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cyc_kind,
  input  logic [ADDR_W-1:0] ear,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] sp_load_val,
  input  logic [ADDR_W-1:0] pc_load_val,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] pc
);
  cyc_kind_e kind;
  logic      rst_sync_n;
  logic      sp_inc, sp_dec, pc_inc, cap_en;

  assign kind   = cyc_kind_e'(cyc_kind);
  assign sp_inc = (kind == CYC_PULL);
  assign sp_dec = (kind == CYC_PUSH);
  assign pc_inc = (kind == CYC_PROG);
  assign cap_en = kind_captures(kind);

  bcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bcs_ptr_reg #(.ADDR_W(ADDR_W), .RST_VAL(SP_RST), .CAN_DEC(1'b1)) u_sp (
    .clk(clk), .rst_n(rst_sync_n), .load(ptr_load), .load_val(sp_load_val),
    .inc_en(sp_inc), .dec_en(sp_dec), .ptr(sp)
  );

  bcs_ptr_reg #(.ADDR_W(ADDR_W), .RST_VAL(PC_RST), .CAN_DEC(1'b0)) u_pc (
    .clk(clk), .rst_n(rst_sync_n), .load(ptr_load), .load_val(pc_load_val),
    .inc_en(pc_inc), .dec_en(1'b0), .ptr(pc)
  );

  bcs_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .kind(kind), .ear(ear), .sp(sp), .pc(pc), .wr_data(wr_data),
    .addr(bus_addr), .rw(bus_rw), .drive(bus_drive), .wdata(bus_wdata)
  );

  bcs_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(cap_en),
    .bus_rdata(bus_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        kind,
  input logic              ptr_load,
  input logic [ADDR_W-1:0] sp_load_val,
  input logic [ADDR_W-1:0] pc_load_val,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rw,
  input logic              bus_drive,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] pc
);
  import bcs_pkg::*;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_PROG && !ptr_load) |=> (pc == $past(pc) + ONE && $stable(sp))); // R2

  AST_DATA_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == CYC_DREAD || kind == CYC_DWRITE) && !ptr_load) |=> ($stable(sp) && $stable(pc))); // R3

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_PUSH && !ptr_load) |=> (sp == $past(bus_addr) - ONE)); // R4

  AST_PULL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_PULL && !ptr_load) |=> (sp == $past(bus_addr))); // R5

  AST_NULL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_NULL) |-> (bus_addr == '1 && bus_rw)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_NULL || kind == CYC_DSP || kind == CYC_DPC) |=> $stable(rd_data)); // R7

  AST_RW_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(bus_rw) && (bus_rw != bus_drive)); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (sp == $past(sp_load_val) && pc == $past(pc_load_val))); // R10
endmodule

bind bus_cycle_seq bcs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .kind(cyc_kind), .ptr_load(ptr_load),
  .sp_load_val(sp_load_val), .pc_load_val(pc_load_val), .bus_addr(bus_addr),
  .bus_rw(bus_rw), .bus_drive(bus_drive), .rd_data(rd_data), .sp(sp), .pc(pc)
);

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] ear;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [15:0] e_addr;
    logic        e_rw;
    logic [15:0] e_sp;
    logic [15:0] e_pc;
    logic [7:0]  e_rd;
  } vec_t;

  // Codes: 0 fetch, 1 data read, 2 data write, 3 push, 4 pull, 5 null, 6 dummy SP, 7 dummy PC
  localparam int NV = 12;
  localparam vec_t VEC [0:NV-1] = '{
    '{3'd0, 16'h0000, 8'h00, 8'hA1, 16'hE000, 1'b1, 16'h01FF, 16'hE001, 8'hA1},
    '{3'd0, 16'h0000, 8'h00, 8'h5C, 16'hE001, 1'b1, 16'h01FF, 16'hE002, 8'h5C},
    '{3'd1, 16'h1234, 8'h00, 8'h77, 16'h1234, 1'b1, 16'h01FF, 16'hE002, 8'h77},
    '{3'd2, 16'h0040, 8'h3E, 8'h99, 16'h0040, 1'b0, 16'h01FF, 16'hE002, 8'h77},
    '{3'd3, 16'h0000, 8'h11, 8'h98, 16'h01FF, 1'b0, 16'h01FE, 16'hE002, 8'h77},
    '{3'd3, 16'h0000, 8'h22, 8'h97, 16'h01FE, 1'b0, 16'h01FD, 16'hE002, 8'h77},
    '{3'd5, 16'h0000, 8'h00, 8'hEE, 16'hFFFF, 1'b1, 16'h01FD, 16'hE002, 8'h77},
    '{3'd6, 16'h0000, 8'h00, 8'hDD, 16'h01FD, 1'b1, 16'h01FD, 16'hE002, 8'h77},
    '{3'd7, 16'h0000, 8'h00, 8'hCC, 16'hE002, 1'b1, 16'h01FD, 16'hE002, 8'h77},
    '{3'd4, 16'h0000, 8'h00, 8'h22, 16'h01FE, 1'b1, 16'h01FE, 16'hE002, 8'h22},
    '{3'd4, 16'h0000, 8'h00, 8'h11, 16'h01FF, 1'b1, 16'h01FF, 16'hE002, 8'h11},
    '{3'd0, 16'h0000, 8'h00, 8'h90, 16'hE002, 1'b1, 16'h01FF, 16'hE003, 8'h90}
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  cyc_kind;
  logic [15:0] ear, sp_load_val, pc_load_val;
  logic [7:0]  wr_data, bus_rdata;
  logic        ptr_load;
  logic [15:0] bus_addr, sp, pc;
  logic        bus_rw, bus_drive;
  logic [7:0]  bus_wdata, rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .ear(ear), .wr_data(wr_data),
    .bus_rdata(bus_rdata), .ptr_load(ptr_load), .sp_load_val(sp_load_val),
    .pc_load_val(pc_load_val), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_drive(bus_drive), .bus_wdata(bus_wdata), .rd_data(rd_data), .sp(sp), .pc(pc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [15:0] e, input logic [7:0] wd,
                       input logic [7:0] rd, input logic ld, input logic [15:0] spv,
                       input logic [15:0] pcv);
    @(negedge clk);
    cyc_kind = k; ear = e; wr_data = wd; bus_rdata = rd;
    ptr_load = ld; sp_load_val = spv; pc_load_val = pcv;
    #1;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; cyc_kind = 3'd5; ear = '0; wr_data = '0; bus_rdata = '0;
    ptr_load = 1'b0; sp_load_val = '0; pc_load_val = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sp in reset", 32'(sp), 32'h01FF);
    chk("R1 pc in reset", 32'(pc), 32'hE000);
    chk("R1 rd in reset", 32'(rd_data), 32'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sp after release", 32'(sp), 32'h01FF);
    chk("R1 pc after release", 32'(pc), 32'hE000);

    // Table walk: R2..R9
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].kind, VEC[i].ear, VEC[i].wdata, VEC[i].rdata, 1'b0, '0, '0);
      chk("R2-R8 addr (R2 R3 R4 R5 R6 R7 R8)", 32'(bus_addr), 32'(VEC[i].e_addr));
      chk("R9 rw", 32'(bus_rw), 32'(VEC[i].e_rw));
      chk("R9 drive opposite rw", 32'(bus_drive), 32'(!VEC[i].e_rw));
      if (!VEC[i].e_rw) chk("R3 R4 write data", 32'(bus_wdata), 32'(VEC[i].wdata));
      settle();
      chk("R4 R5 sp after", 32'(sp), 32'(VEC[i].e_sp));
      chk("R2 pc after", 32'(pc), 32'(VEC[i].e_pc));
      chk("R6 R7 R8 rd after", 32'(rd_data), 32'(VEC[i].e_rd));
    end

    // R10: load in same cycle as push
    drive(3'd3, '0, 8'h44, 8'h00, 1'b1, 16'h0100, 16'h1000);
    chk("R10 push addr uses old sp", 32'(bus_addr), 32'h01FF);
    settle();
    chk("R10 sp loaded over push", 32'(sp), 32'h0100);
    chk("R10 pc loaded", 32'(pc), 32'h1000);
    // R10: load with fetch, capture still happens
    drive(3'd0, '0, '0, 8'h6B, 1'b1, 16'h0200, 16'h2000);
    chk("R10 fetch addr uses old pc", 32'(bus_addr), 32'h1000);
    settle();
    chk("R10 pc loaded over fetch", 32'(pc), 32'h2000);
    chk("R10 capture with load", 32'(rd_data), 32'h6B);
    // R10: load with pull, capture still happens
    drive(3'd4, '0, '0, 8'h3C, 1'b1, 16'hFFFF, 16'hFFFF);
    chk("R10 pull addr uses old sp", 32'(bus_addr), 32'h0201);
    settle();
    chk("R10 sp loaded over pull", 32'(sp), 32'hFFFF);
    chk("R10 pull capture with load", 32'(rd_data), 32'h3C);

    // R11 wraparound
    drive(3'd0, '0, '0, 8'h01, 1'b0, '0, '0);
    chk("R11 fetch at top", 32'(bus_addr), 32'hFFFF);
    settle();
    chk("R11 pc wraps", 32'(pc), 32'h0000);
    drive(3'd4, '0, '0, 8'h02, 1'b0, '0, '0);
    chk("R11 pull addr wraps", 32'(bus_addr), 32'h0000);
    settle();
    chk("R11 sp after pull wrap", 32'(sp), 32'h0000);
    drive(3'd3, '0, 8'h55, 8'h00, 1'b0, '0, '0);
    chk("R11 push at zero", 32'(bus_addr), 32'h0000);
    settle();
    chk("R11 sp wraps down", 32'(sp), 32'hFFFF);
    chk("R6 pc untouched by push", 32'(pc), 32'h0000);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async sp reset", 32'(sp), 32'h01FF);
    chk("R1 async pc reset", 32'(pc), 32'hE000);
    chk("R1 async rd reset", 32'(rd_data), 32'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule